// File: doc/BRIEF.md
# Link Error Event Signature Logger

This block watches eleven error flags from a serial link and groups them into events. The flags come from three levels: the transceiver tile, the link protocol engine and the data integrity checker. A flag that asserts while the logger is idle opens an event. The logger then writes a start record. That record holds a free-running timestamp and the signature, which is the set of flags that asserted in that first cycle. Later flags do not change the signature. They are OR-ed into a running set instead. The event closes once no flag has asserted for a programmable number of cycles, and the logger then writes an end record with the closing timestamp and the accumulated set.

Records leave on a valid/ready stream and each is presented as one wide word. The block holds at most one start record and one end record. An event that opens while earlier records are still waiting is dropped whole. A sticky overflow bit reports the drop. This keeps the record order intact. Typical use sets the quiet window to 1024 cycles.

Top module: `event_sig_logger`

## Requirements
- R1: The record flag field is {data_err, proto_err, tile_err}. Bits 0..4 are tile flags (RX disparity, RX symbol not in table, RX realign, RX buffer, TX buffer). Bits 5..8 are protocol flags (hard error, soft error, frame error, RX/TX reset activity). Bit 9 is CRC failure and bit 10 is missing frame.
- R2: When any flag is high in a cycle while no event is open and no record is waiting, a start record is emitted. A start record has rec_end=0, the timestamp of that cycle, and all flags high in that cycle as its signature. rec_valid rises one cycle later.
- R3: Flags seen after the first cycle of an event leave the signature unchanged. Their OR (excluding the first cycle) is the flag field of the end record. The field is zero if no later flag occurred.
- R4: An event ends after quiet_len consecutive flag-free cycles. Its end record has rec_end=1 and timestamp L+quiet_len, where L is the timestamp of the last cycle with a flag. A flag after quiet_len-1 quiet cycles extends the event.
- R5: A start record is always delivered before its own end record. A record presented while rec_ready is low stays stable until it is accepted.
- R6: An event that opens while any record is still waiting is dropped. The event emits no record, and its flags keep it open until its own quiet window ends. overflow goes high and stays high until reset.
- R7: After reset, rec_valid and overflow are 0 and the timestamp is 0. rst_n asserts asynchronously. Its release takes effect after two rising clock edges, and from then on the timestamp counts every rising edge. The timestamp is 40 bits and wraps silently.
- R8: A quiet_len of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quiet_len | input | 16 | Flag-free cycles that close an event |
| tile_err | input | 5 | Transceiver tile error flags |
| proto_err | input | 4 | Link protocol error flags |
| data_err | input | 2 | Data check error flags |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_valid | output | 1 | A record is presented |
| rec_end | output | 1 | 0 for a start record, 1 for an end record |
| rec_stamp | output | 40 | Timestamp of the record |
| rec_flags | output | 11 | Signature (start) or accumulated flags (end) |
| overflow | output | 1 | Sticky: an event was dropped |

## Verification
The bench opens events with several flags in the first cycle and adds more flags later. A logger that kept the union in the signature, or left the first-cycle flags out, would produce a wrong start or end field. It places a flag exactly quiet_len-1 cycles after the last one. An off-by-one quiet counter would split that event in two and emit an extra pair of records. It stalls the stream so that a second event opens while records wait. A wrong design would then reorder records, emit records for the dropped event or fail to latch overflow. A quiet_len of 0 is also driven, which a plain compare would turn into an almost endless window.

// File: rtl/lel_pkg.sv
package lel_pkg;
  localparam int NUM_TILE  = 5;
  localparam int NUM_PROTO = 4;
  localparam int NUM_DATA  = 2;
  localparam int FLAG_W    = NUM_TILE + NUM_PROTO + NUM_DATA;

  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_LIVE = 2'd1,
    EV_DROP = 2'd2
  } ev_state_t;
endpackage

// File: rtl/lel_reset_sync.sv
module lel_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/lel_stamp.sv
module lel_stamp #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] stamp
);
  logic [W-1:0] stamp_q;
  logic [W-1:0] stamp_d;

  always_comb stamp_d = stamp_q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stamp_q <= '0;
    else        stamp_q <= stamp_d;
  end

  assign stamp = stamp_q;
endmodule

// File: rtl/lel_event_fsm.sv
module lel_event_fsm
  import lel_pkg::*;
#(
  parameter int FW = 11,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] flags,
  input  logic [QW-1:0] quiet_len,
  input  logic          pending,
  output logic          start_we,
  output logic          end_we,
  output logic [FW-1:0] accum,
  output logic          overflow
);
  ev_state_t     st_q, st_d;
  logic [QW-1:0] cnt_q, cnt_d;
  logic [FW-1:0] acc_q, acc_d;
  logic          ovf_q, ovf_d;
  logic          any_flag;
  logic [QW-1:0] q_eff;
  logic          quiet_hit;
  logic          en;

  assign any_flag  = |flags;
  assign q_eff     = (quiet_len == '0) ? QW'(1) : quiet_len;
  assign quiet_hit = !any_flag && (cnt_q == q_eff - QW'(1));

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    ovf_d    = ovf_q;
    start_we = 1'b0;
    end_we   = 1'b0;
    unique case (st_q)
      EV_IDLE: begin
        if (any_flag) begin
          cnt_d = '0;
          acc_d = '0;
          if (pending) begin
            st_d  = EV_DROP;
            ovf_d = 1'b1;
          end else begin
            st_d     = EV_LIVE;
            start_we = 1'b1;
          end
        end
      end
      EV_LIVE, EV_DROP: begin
        if (any_flag) begin
          cnt_d = '0;
          acc_d = acc_q | flags;
        end else if (quiet_hit) begin
          st_d   = EV_IDLE;
          end_we = (st_q == EV_LIVE);
        end else begin
          cnt_d = cnt_q + QW'(1);
        end
      end
      default: st_d = EV_IDLE;
    endcase
  end

  assign en = any_flag || (st_q != EV_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= EV_IDLE;
      cnt_q <= '0;
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign accum    = acc_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/lel_rec_buf.sv
module lel_rec_buf #(
  parameter int RW = 52
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_we,
  input  logic [RW-1:0] start_rec,
  input  logic          end_we,
  input  logic [RW-1:0] end_rec,
  output logic          pending,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [RW-1:0] out_rec
);
  logic          s_v_q, s_v_d, e_v_q, e_v_d;
  logic [RW-1:0] s_r_q, e_r_q;
  logic          pop;

  assign pop = out_valid && out_ready;

  always_comb begin
    s_v_d = s_v_q;
    e_v_d = e_v_q;
    if (pop && s_v_q)                s_v_d = 1'b0;
    else if (pop && e_v_q)           e_v_d = 1'b0;
    if (start_we)                    s_v_d = 1'b1;
    if (end_we)                      e_v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_v_q <= 1'b0;
      e_v_q <= 1'b0;
    end else begin
      s_v_q <= s_v_d;
      e_v_q <= e_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        s_r_q <= '0;
    else if (start_we) s_r_q <= start_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      e_r_q <= '0;
    else if (end_we) e_r_q <= end_rec;
  end

  assign pending   = s_v_q || e_v_q;
  assign out_valid = pending;
  assign out_rec   = s_v_q ? s_r_q : e_r_q;
endmodule

// File: rtl/event_sig_logger.sv
module event_sig_logger
  import lel_pkg::*;
#(
  parameter int TS_W = 40,
  parameter int QW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [QW-1:0]         quiet_len,
  input  logic [NUM_TILE-1:0]   tile_err,
  input  logic [NUM_PROTO-1:0]  proto_err,
  input  logic [NUM_DATA-1:0]   data_err,
  input  logic                  rec_ready,
  output logic                  rec_valid,
  output logic                  rec_end,
  output logic [TS_W-1:0]       rec_stamp,
  output logic [FLAG_W-1:0]     rec_flags,
  output logic                  overflow
);
  localparam int RW = 1 + TS_W + FLAG_W;

  logic              rst_n_int;
  logic [TS_W-1:0]   stamp;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] accum;
  logic              start_we, end_we, pending;
  logic [RW-1:0]     start_rec, end_rec, out_rec;

  assign flags     = {data_err, proto_err, tile_err};
  assign start_rec = {1'b0, stamp, flags};
  assign end_rec   = {1'b1, stamp, accum};

  lel_reset_sync #(.STAGES(2)) rsync_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_int)
  );

  lel_stamp #(.W(TS_W)) stamp_i (
    .clk(clk), .rst_n(rst_n_int), .stamp(stamp)
  );

  lel_event_fsm #(.FW(FLAG_W), .QW(QW)) fsm_i (
    .clk(clk), .rst_n(rst_n_int), .flags(flags), .quiet_len(quiet_len),
    .pending(pending), .start_we(start_we), .end_we(end_we),
    .accum(accum), .overflow(overflow)
  );

  lel_rec_buf #(.RW(RW)) buf_i (
    .clk(clk), .rst_n(rst_n_int), .start_we(start_we), .start_rec(start_rec),
    .end_we(end_we), .end_rec(end_rec), .pending(pending),
    .out_valid(rec_valid), .out_ready(rec_ready), .out_rec(out_rec)
  );

  assign rec_end   = out_rec[RW-1];
  assign rec_stamp = out_rec[RW-2 -: TS_W];
  assign rec_flags = out_rec[FLAG_W-1:0];
endmodule

// File: rtl/event_sig_logger_chk.sv
module event_sig_logger_chk #(
  parameter int TS_W   = 40,
  parameter int FLAG_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic              rec_end,
  input logic [TS_W-1:0]   rec_stamp,
  input logic [FLAG_W-1:0] rec_flags,
  input logic              overflow
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    open_q <= 1'b0;
    else if (rec_valid && rec_ready) open_q <= !rec_end;
  end

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_end)
      && $stable(rec_stamp) && $stable(rec_flags));

  p_end_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_ready && rec_end |-> open_q);

  p_no_double_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_ready && !rec_end |-> !open_q);

  p_sig_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_end |-> rec_flags != '0);

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind event_sig_logger event_sig_logger_chk #(.TS_W(TS_W), .FLAG_W(FLAG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_end(rec_end), .rec_stamp(rec_stamp), .rec_flags(rec_flags),
  .overflow(overflow)
);

// File: tb/event_sig_logger_tb_top.sv
`timescale 1ns/1ps
module event_sig_logger_tb_top;
  localparam int TS_W = 40;
  localparam int FW   = 11;
  localparam int RW   = 1 + TS_W + FW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     quiet_len = 16'd16;
  logic [4:0]      tile_err = '0;
  logic [3:0]      proto_err = '0;
  logic [1:0]      data_err = '0;
  logic            rec_ready = 1'b1;
  logic            rec_valid, rec_end, overflow;
  logic [TS_W-1:0] rec_stamp;
  logic [FW-1:0]   rec_flags;

  int      checks = 0;
  int      errors = 0;
  bit      done = 1'b0;
  longint  bcyc = 0;
  logic [RW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  event_sig_logger dut_i (
    .clk(clk), .rst_n(rst_n), .quiet_len(quiet_len), .tile_err(tile_err),
    .proto_err(proto_err), .data_err(data_err), .rec_ready(rec_ready),
    .rec_valid(rec_valid), .rec_end(rec_end), .rec_stamp(rec_stamp),
    .rec_flags(rec_flags), .overflow(overflow)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcyc <= 0;
    else        bcyc <= bcyc + 1;

  function automatic logic [TS_W-1:0] now_ts();
    return TS_W'(bcyc - 2);
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push(input bit e, input logic [TS_W-1:0] t, input logic [FW-1:0] f, input string tag);
    exp_q.push_back({e, t, f});
    tag_q.push_back(tag);
  endtask

  // monitor: compares every accepted record against the expected queue
  always @(negedge clk) begin
    #1;
    if (rst_n && rec_valid && rec_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected record", longint'({rec_end, rec_stamp, rec_flags}), 0);
      end else begin
        logic [RW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rec_end, rec_stamp, rec_flags} == e, t,
              longint'({rec_end, rec_stamp, rec_flags}), longint'(e));
      end
    end
  end

  task automatic cyc(input logic [FW-1:0] f);
    {data_err, proto_err, tile_err} = f;
    @(negedge clk);
  endtask

  // one event: signature, then optional later flags after gap quiet cycles
  task automatic ev(input logic [FW-1:0] sig, input int gap, input logic [FW-1:0] extra,
                    input int q, input bit expect_rec, input string tag);
    logic [TS_W-1:0] t0, tl;
    t0 = now_ts();
    tl = t0;
    if (expect_rec) push(1'b0, t0, sig, {tag, " start"});
    cyc(sig);
    if (extra != '0) begin
      repeat (gap) cyc('0);
      tl = now_ts();
      cyc(extra);
    end
    if (expect_rec) push(1'b1, tl + TS_W'(q), extra, {tag, " end"});
    repeat (q + 3) cyc('0);
  endtask

  task automatic drained(input string tag);
    check(exp_q.size() == 0, {tag, " queue drained"}, exp_q.size(), 0);
    check(rec_valid == 1'b0, {tag, " stream idle"}, rec_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rec_valid == 1'b0, "R7 reset rec_valid", rec_valid, 0);
    check(overflow == 1'b0, "R7 reset overflow", overflow, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7 R2 R1: first event timestamp from reset; tile bits 0 and 3
    ev(11'h009, 0, '0, 16, 1'b1, "R7 R2 R1 tile sig");
    drained("R2");
    // R3 R1: two protocol bits then a data bit (CRC, bit 9) and a repeat of bit 5
    ev(11'h060, 4, 11'h220, 16, 1'b1, "R3 R1 proto sig");
    drained("R3");
    // R4 boundary: extra flag exactly quiet_len-1 quiet cycles later extends event
    ev(11'h400, 15, 11'h010, 16, 1'b1, "R4 edge extend");
    drained("R4");
    // R8: quiet_len 0 acts as 1
    quiet_len = 16'd0;
    @(negedge clk);
    ev(11'h100, 0, '0, 1, 1'b1, "R8 quiet zero");
    drained("R8");
    quiet_len = 16'd16;
    @(negedge clk);

    // R5 R6: stall, open a second event while records wait
    rec_ready = 1'b0;
    ev(11'h081, 2, 11'h002, 16, 1'b1, "R5 stalled");
    ev(11'h200, 0, '0, 16, 1'b0, "R6 dropped");
    check(overflow == 1'b1, "R6 overflow set", overflow, 1);
    check(rec_valid == 1'b1 && rec_end == 1'b0, "R5 start at head", rec_end, 0);
    rec_ready = 1'b1;
    repeat (6) @(negedge clk);
    drained("R6 no dropped records");
    ev(11'h004, 0, '0, 16, 1'b1, "R6 after drop");
    drained("R6");
    check(overflow == 1'b1, "R6 overflow sticky", overflow, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule